// File: doc/BRIEF.md
# UART Automatic Flow Controller

This block sits next to one UART channel and takes over both styles of flow control. It compares the receive FIFO fill level with two programmed limits. When the FIFO gets full it tells the far end to stop, either by dropping RTS or by asking the transmit path to send an Xoff character. When the FIFO drains again it tells the far end to resume, by raising RTS or by asking for an Xon.

In the outgoing direction it decides whether the local transmitter may start a new character. That decision depends on the CTS input level and on the Xon/Xoff characters received from the far end. The decision is re-evaluated only while the transmitter is idle, so a character already on the line is never cut short.

Software programs the two thresholds, the two control characters and four enable bits through a small write-only register port. Serial framing, the FIFOs and the baud clock live elsewhere.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset, rts is 1, sp_req is 0 and tx_fifo_ok is 1. All thresholds, characters and enable bits are zero after reset.
- R2: The thresholds are valid only when resume is less than halt. With valid thresholds and not already halted, a rx_level at or above halt sets the halted state on the next clock edge. While auto-RTS is enabled, rts is 0 whenever the halted state is set.
- R3: While halted, a rx_level at or below resume clears the halted state on the next clock edge, and rts returns to 1.
- R4: When resume is greater than or equal to halt, the halted state clears or stays clear on the next edge, whatever rx_level is.
- R5: With software flow control enabled, each change of the halted state raises sp_req on the next edge. sp_char carries the Xoff character for a change into halted and the Xon character for a change out of halted. sp_req holds until sp_ack is seen high with it. A new change in the same cycle as an ack replaces the old request. Disabling software flow control drops any pending request.
- R6: While sp_req is 1, tx_fifo_ok is 0, so control characters take priority over FIFO data.
- R7: With auto-CTS enabled, the transmit permission follows cts one edge later, but only in cycles where tx_busy is 0. While tx_busy is 1, the permission is frozen.
- R8: With software flow control enabled, a received Xoff character (rx_valid with rx_char equal to the Xoff register) sets a hold. A received Xon clears the hold. If a character equals both registers, Xoff wins. While held, the transmit permission drops at the next idle edge after the hold takes effect.
- R9: With the resume-on-any bit also set, any received character other than Xoff clears the hold.
- R10: rx_keep is rx_valid, except that it is 0 for Xon and Xoff characters while software flow control is enabled.
- R11: Register map, written with cfg_we on cfg_addr, taking effect on the next edge: 0 halt level, 1 resume level, 2 Xon character, 3 Xoff character, 4 enables. The enable bits are bit0 auto-RTS, bit1 auto-CTS, bit2 software flow control and bit3 resume-on-any.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| rx_level | input | 7 | Receive FIFO fill level, 0 to 64 |
| rx_valid | input | 1 | A received character is presented |
| rx_char | input | 8 | Received character |
| rx_keep | output | 1 | Write the presented character into the receive FIFO |
| cts | input | 1 | Far end clear to send, 1 = clear |
| rts | output | 1 | Request to send toward far end, 1 = ready |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_fifo_ok | output | 1 | Transmitter may start a FIFO character |
| sp_req | output | 1 | Control character send request |
| sp_char | output | 8 | Control character to send |
| sp_ack | input | 1 | Transmitter accepted the control character |

## Verification
Two events can land in the same clock: the transmitter acknowledges a pending Xon or Xoff request, and the fill level crosses a threshold, which raises a fresh request. The stimulus moves the fill level in random jumps that cross both limits often, and it acks at random. Because of this, acks regularly coincide with threshold crossings. In those cycles the bench expects the new request to remain pending with the new character, and it compares sp_req and sp_char every cycle against its own model. The second coincidence is a received Xoff arriving while tx_busy is high. Here the bench expects the permission to move only at the first idle edge after the hold takes effect.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
  localparam int DEPTH  = 64;
  localparam int LVL_W  = $clog2(DEPTH + 1);
  localparam int CHAR_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_HALT   = 3'd0;
  localparam logic [ADDR_W-1:0] A_RESUME = 3'd1;
  localparam logic [ADDR_W-1:0] A_XON    = 3'd2;
  localparam logic [ADDR_W-1:0] A_XOFF   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;

  typedef struct packed {
    logic xon_any;
    logic sw_en;
    logic auto_cts;
    logic auto_rts;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef struct packed {
    ctrl_t             ctrl;
    logic [LVL_W-1:0]  halt;
    logic [LVL_W-1:0]  resume;
    logic [CHAR_W-1:0] xon;
    logic [CHAR_W-1:0] xoff;
  } cfg_t;
endpackage

// File: rtl/ufc_regs.sv
module ufc_regs
  import ufc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CHAR_W-1:0] wdata,
  output cfg_t              cfg
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      case (addr)
        A_HALT:   cfg_d.halt   = wdata[LVL_W-1:0];
        A_RESUME: cfg_d.resume = wdata[LVL_W-1:0];
        A_XON:    cfg_d.xon    = wdata;
        A_XOFF:   cfg_d.xoff   = wdata;
        A_CTRL:   cfg_d.ctrl   = ctrl_t'(wdata[CTRL_W-1:0]);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (we) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  p_write_ctrl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_CTRL) |=> (cfg_q.ctrl == ctrl_t'($past(wdata[CTRL_W-1:0]))));
endmodule

// File: rtl/ufc_rx_watch.sv
module ufc_rx_watch
  import ufc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              sp_ack,
  output logic              rts,
  output logic              sp_req,
  output logic [CHAR_W-1:0] sp_char
);
  logic thr_valid;
  logic halted_q, halted_d;
  logic pend_q, pend_d;
  logic isxoff_q, isxoff_d;
  logic edge_up, edge_dn;

  assign thr_valid = (cfg.resume < cfg.halt);

  always_comb begin
    halted_d = halted_q;
    if (!thr_valid)                                halted_d = 1'b0;
    else if (!halted_q && rx_level >= cfg.halt)   halted_d = 1'b1;
    else if (halted_q && rx_level <= cfg.resume)  halted_d = 1'b0;
  end

  assign edge_up = halted_d & ~halted_q;
  assign edge_dn = ~halted_d & halted_q;

  always_comb begin
    pend_d   = pend_q;
    isxoff_d = isxoff_q;
    if (!cfg.ctrl.sw_en) begin
      pend_d = 1'b0;
    end else if (edge_up || edge_dn) begin
      pend_d   = 1'b1;
      isxoff_d = edge_up;
    end else if (pend_q && sp_ack) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      pend_q   <= 1'b0;
      isxoff_q <= 1'b0;
    end else begin
      halted_q <= halted_d;
      pend_q   <= pend_d;
      isxoff_q <= isxoff_d;
    end
  end

  assign rts     = ~(cfg.ctrl.auto_rts & halted_q);
  assign sp_req  = pend_q;
  assign sp_char = isxoff_q ? cfg.xoff : cfg.xon;

  p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_valid && !halted_q && rx_level >= cfg.halt) |=> halted_q);
  p_resume_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_valid && halted_q && rx_level <= cfg.resume) |=> !halted_q);
  p_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_valid |=> !halted_q);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_req && !sp_ack && cfg.ctrl.sw_en) |=> sp_req);
endmodule

// File: rtl/ufc_tx_gate.sv
module ufc_tx_gate
  import ufc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              cts,
  input  logic              tx_busy,
  output logic              tx_go,
  output logic              rx_keep
);
  logic is_xon, is_xoff;
  logic hold_q, hold_d;
  logic go_q, go_d;
  logic clear_ok;

  assign is_xoff  = (rx_char == cfg.xoff);
  assign is_xon   = (rx_char == cfg.xon);
  assign clear_ok = ~cfg.ctrl.auto_cts | cts;

  always_comb begin
    hold_d = hold_q;
    if (!cfg.ctrl.sw_en)            hold_d = 1'b0;
    else if (rx_valid) begin
      if (is_xoff)                  hold_d = 1'b1;
      else if (is_xon)              hold_d = 1'b0;
      else if (cfg.ctrl.xon_any)    hold_d = 1'b0;
    end
  end

  always_comb begin
    go_d = go_q;
    if (!tx_busy) go_d = clear_ok & ~hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      go_q   <= 1'b1;
    end else begin
      hold_q <= hold_d;
      go_q   <= go_d;
    end
  end

  assign tx_go   = go_q;
  assign rx_keep = rx_valid & ~(cfg.ctrl.sw_en & (is_xon | is_xoff));

  p_busy_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> $stable(go_q));
  p_xoff_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.ctrl.sw_en && rx_valid && is_xoff) |=> hold_q);
  p_any_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.ctrl.sw_en && cfg.ctrl.xon_any && rx_valid && !is_xoff) |=> !hold_q);
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import ufc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CHAR_W-1:0] cfg_wdata,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              rx_keep,
  input  logic              cts,
  output logic              rts,
  input  logic              tx_busy,
  output logic              tx_fifo_ok,
  output logic              sp_req,
  output logic [CHAR_W-1:0] sp_char,
  input  logic              sp_ack
);
  cfg_t cfg;
  logic tx_go;

  ufc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  ufc_rx_watch u_rx (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .rx_level(rx_level),
    .sp_ack(sp_ack), .rts(rts), .sp_req(sp_req), .sp_char(sp_char)
  );

  ufc_tx_gate u_tx (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .rx_valid(rx_valid),
    .rx_char(rx_char), .cts(cts), .tx_busy(tx_busy),
    .tx_go(tx_go), .rx_keep(rx_keep)
  );

  assign tx_fifo_ok = tx_go & ~sp_req;

  p_ctl_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_req |-> !tx_fifo_ok);
endmodule

// File: tb/uart_flow_ctl_tb_top.sv
module uart_flow_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [6:0] rx_level = '0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_char = '0;
  logic cts = 1'b1, tx_busy = 1'b0, sp_ack = 1'b0;
  logic rx_keep, rts, tx_fifo_ok, sp_req;
  logic [7:0] sp_char;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model of the block state
  int m_halt, m_res, m_xon, m_xoff;
  bit m_arts, m_acts, m_sw, m_any;
  bit m_fh, m_pend, m_isx, m_hold, m_go;

  always #5 clk = ~clk;

  uart_flow_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_level(rx_level), .rx_valid(rx_valid),
    .rx_char(rx_char), .rx_keep(rx_keep), .cts(cts), .rts(rts),
    .tx_busy(tx_busy), .tx_fifo_ok(tx_fifo_ok), .sp_req(sp_req),
    .sp_char(sp_char), .sp_ack(sp_ack)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_keep();
    if (!rx_valid) return 0;
    return !(m_sw && (rx_char == m_xon[7:0] || rx_char == m_xoff[7:0]));
  endfunction

  task automatic compare();
    chk("R2 R3 R4 R11 rts", rts, !(m_arts && m_fh));
    chk("R5 sp_req", sp_req, m_pend);
    if (m_pend) chk("R5 sp_char", sp_char, m_isx ? m_xoff : m_xon);
    chk("R6 R7 R8 R9 tx_fifo_ok", tx_fifo_ok, m_go && !m_pend);
    chk("R10 rx_keep", rx_keep, exp_keep());
  endtask

  task automatic model_edge();
    bit tv, fh_n, pend_n, isx_n, hold_n, go_n;
    tv = m_res < m_halt;
    fh_n = m_fh;
    if (!tv) fh_n = 0;
    else if (!m_fh && rx_level >= m_halt) fh_n = 1;
    else if (m_fh && rx_level <= m_res) fh_n = 0;
    pend_n = m_pend; isx_n = m_isx;
    if (!m_sw) pend_n = 0;
    else if (fh_n != m_fh) begin pend_n = 1; isx_n = fh_n; end
    else if (m_pend && sp_ack) pend_n = 0;
    hold_n = m_hold;
    if (!m_sw) hold_n = 0;
    else if (rx_valid) begin
      if (rx_char == m_xoff[7:0]) hold_n = 1;
      else if (rx_char == m_xon[7:0]) hold_n = 0;
      else if (m_any) hold_n = 0;
    end
    go_n = tx_busy ? m_go : ((!m_acts || cts) && !m_hold);
    m_fh = fh_n; m_pend = pend_n; m_isx = isx_n; m_hold = hold_n; m_go = go_n;
    if (cfg_we) case (cfg_addr)
      3'd0: m_halt = cfg_wdata[6:0];
      3'd1: m_res  = cfg_wdata[6:0];
      3'd2: m_xon  = cfg_wdata;
      3'd3: m_xoff = cfg_wdata;
      3'd4: begin m_arts = cfg_wdata[0]; m_acts = cfg_wdata[1];
                  m_sw = cfg_wdata[2]; m_any = cfg_wdata[3]; end
      default: ;
    endcase
  endtask

  // called at a falling edge with inputs set
  task automatic cycle();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    cycle();
  endtask

  task automatic rand_run(int n, int step);
    int lv;
    for (int i = 0; i < n; i++) begin
      lv = int'(rx_level) + $urandom_range(0, 2*step) - step;
      if (lv < 0) lv = 0;
      if (lv > 64) lv = 64;
      rx_level = 7'(lv);
      rx_valid = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 3))
        0: rx_char = 8'(m_xon);
        1: rx_char = 8'(m_xoff);
        default: rx_char = 8'($urandom);
      endcase
      cts = ($urandom_range(0, 3) != 0);
      tx_busy = ($urandom_range(0, 1) == 1);
      sp_ack = ($urandom_range(0, 2) == 0);
      cycle();
    end
  endtask

  initial begin
    void'($urandom(32'h0000_5eed));
    m_halt = 0; m_res = 0; m_xon = 0; m_xoff = 0;
    m_arts = 0; m_acts = 0; m_sw = 0; m_any = 0;
    m_fh = 0; m_pend = 0; m_isx = 0; m_hold = 0; m_go = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1;
    chk("R1 rts", rts, 1);
    chk("R1 sp_req", sp_req, 0);
    chk("R1 tx_fifo_ok", tx_fifo_ok, 1);
    // R11 program map
    wr(0, 40); wr(1, 12); wr(2, 8'h11); wr(3, 8'h13); wr(4, 4'b0111);
    // R2 boundary: level exactly at halt
    rx_level = 39; cycle();
    rx_level = 40; cycle(); cycle();
    // R5 ack withheld, then ack
    sp_ack = 0; cycle(); cycle(); sp_ack = 1; cycle(); sp_ack = 0;
    // R3 boundary: level exactly at resume
    rx_level = 13; cycle();
    rx_level = 12; cycle(); cycle();
    // R8 Xoff while busy, then idle
    rx_valid = 1; rx_char = 8'h13; tx_busy = 1; cycle();
    rx_valid = 0; cycle(); cycle(); tx_busy = 0; cycle(); cycle();
    rx_valid = 1; rx_char = 8'h11; cycle(); rx_valid = 0; cycle(); cycle();
    rand_run(3000, 6);
    // R4 equal thresholds disable
    wr(1, 40); rx_level = 64; cycle(); cycle();
    rand_run(1000, 8);
    // R9 resume on any character
    wr(1, 20); wr(4, 4'b1111);
    rand_run(3000, 6);
    // R7 auto-CTS only
    wr(4, 4'b0010);
    rand_run(1000, 6);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule